// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Front End

This block is the bus-facing side of a byte-organised non-volatile memory of 2048 bytes that sits on a two-wire serial bus. It watches the clock line and the open-drain data line, finds START and STOP conditions, and shifts bytes in and out while the clock is high. It decodes the control byte, answers with acknowledge pulses and keeps an 11-bit address counter. Write bytes are handed to a separate page buffer. Read data is fetched from the array through a combinational read port.

The data line is never driven high. The block only produces an enable, `sda_oe`, that pulls the line low when set. The line the block samples, `sda_i`, is the resolved wired-AND level. Both bus inputs are assumed to be glitch-free and already in the `clk` domain. The three block-select bits of a write control byte become address bits 10..8. The word-address byte that follows supplies bits 7..0.

Top module: `eeprom2w_slave`

## Requirements
- R1: After a synchronous reset, `sda_oe` is 0, no write strobe is active, and the address counter (`rd_addr`) is 0.
- R2: The control byte carries, MSB first, the device code in bits 7..4, the block bits in 3..1 and the direction in bit 0 (1 = read). With code 1010 the slave acknowledges by holding `sda_oe` high through the whole ninth clock-high period. With any other code it gives no acknowledge and ignores all clocks until the next START.
- R3: In a write, the byte after the control byte is acknowledged and sets the address to {block bits, byte}. Each later data byte is acknowledged and presented for one cycle on `wr_valid`, `wr_addr` and `wr_data`. The address then rises by one across the full 11-bit space, including block boundaries.
- R4: A STOP that arrives at a byte boundary after at least one data byte gives exactly one single-cycle `wr_commit` pulse.
- R5: A STOP in the middle of a data byte, or a START after data bytes, gives one `wr_abort` pulse and no `wr_commit`.
- R6: A write control byte plus a word-address byte, followed by a repeated START and a read control byte, returns the byte stored at that address, MSB first.
- R7: While the master acknowledges each read byte, the reads continue at the next address and wrap from 0x7FF to 0x000.
- R8: A read byte that the master does not acknowledge ends the read. The slave releases the line and ignores further clocks until a START.
- R9: A read control byte with no word-address phase continues at the last accessed address plus one. Its block bits are not used.
- R10: While `write_busy` is high, START and STOP are ignored and no acknowledge is given.
- R11: Outside reset and `write_busy`, `sda_oe` changes only while the clock line is low.
- R12: Nine clocks with the data line floating high right after START produce no acknowledge and leave the slave in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock level, synchronised |
| sda_i | input | 1 | Resolved bus data level, synchronised |
| sda_oe | output | 1 | 1 pulls the data line low |
| write_busy | input | 1 | Self-timed array write in progress |
| wr_valid | output | 1 | One-cycle strobe: a write byte is ready |
| wr_addr | output | 11 | Array address of the write byte |
| wr_data | output | 8 | Write byte |
| wr_commit | output | 1 | One-cycle strobe: program the loaded bytes |
| wr_abort | output | 1 | One-cycle strobe: discard the loaded bytes |
| rd_addr | output | 11 | Address counter, used as the read address |
| rd_data | input | 8 | Array byte at `rd_addr` (combinational) |

## Verification
A bad bit counter shows up within one byte. The acknowledge pulse either disappears from the ninth clock or lands on a data clock. The recovered read byte is also shifted by one position. A wrong address counter shows up at the next read byte, or as a wrong `wr_addr` on the next write strobe. The counter is exercised across a block boundary and across the top-of-array wrap. A mis-tracked phase, such as not leaving standby or not returning to it, is seen on the very next byte: an acknowledge is given where none is allowed, or one is missing, and the two commit and abort strobes are counted against every way a write can end.

// File: rtl/eeprom2w_pkg.sv
// Shared constants and the phase type of the two-wire EEPROM slave.
// Assumes the control byte layout: 4-bit code, block bits, direction bit.
package eeprom2w_pkg;
    localparam int BYTE_W  = 8;
    localparam int BLK_W   = 3;
    localparam int CODE_W  = BYTE_W - BLK_W - 1;
    localparam int WADDR_W = BYTE_W;
    localparam int ADDR_W  = BLK_W + WADDR_W;
    localparam int CNT_W   = $clog2(BYTE_W + 2);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CTRL,
        PH_WADDR,
        PH_WDATA,
        PH_RDATA
    } phase_t;
endpackage

// File: rtl/eeprom2w_line_sense.sv
// Samples the bus lines and derives clock edges and START/STOP events.
// Assumes scl_i and sda_i are already synchronous to clk and glitch-free.
module eeprom2w_line_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_hi,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_r, sda_r, scl_p, sda_p;

    // Two-deep history of both lines; idle bus level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_r <= 1'b1;
            sda_r <= 1'b1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_r <= scl_i;
            sda_r <= sda_i;
            scl_p <= scl_r;
            sda_p <= sda_r;
        end
    end

    assign scl_hi   = scl_r;
    assign sda_lvl  = sda_r;
    assign scl_rise = scl_r & ~scl_p;
    assign scl_fall = ~scl_r & scl_p;
    assign start_ev = scl_r & scl_p & sda_p & ~sda_r;
    assign stop_ev  = scl_r & scl_p & ~sda_p & sda_r;
endmodule

// File: rtl/eeprom2w_addr_ctr.sv
// Array address counter: loadable, increments with natural wrap at the top.
// Assumes load and inc are never both needed; load wins if they are.
module eeprom2w_addr_ctr #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] addr
);
    // Holds the next array address to be accessed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= load_val;
        else if (inc)
            addr <= addr + 1'b1;
    end
endmodule

// File: rtl/eeprom2w_slave.sv
// Two-wire bus slave front end for a 2048-byte EEPROM.
// Bits are sampled on clock-high; the slave changes the line only after a
// clock fall. Assumes a combinational array read port (rd_data at rd_addr)
// and an external page buffer fed by the wr_* strobes.
module eeprom2w_slave
    import eeprom2w_pkg::*;
#(
    parameter logic [CODE_W-1:0] DEV_CODE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              write_busy,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_commit,
    output logic              wr_abort,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic scl_hi, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    phase_t            phase;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BLK_W-1:0]  blk;
    logic              m_ack, has_wr;
    logic              ac_load, ac_inc, rd_load, ack_fall;
    logic [ADDR_W-1:0] addr;

    eeprom2w_line_sense u_sense (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_hi(scl_hi), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
    );

    eeprom2w_addr_ctr #(.AW(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(ac_load),
        .load_val({blk, shreg}), .inc(ac_inc), .addr(addr)
    );

    assign rd_addr = addr;

    // Address counter strobes: load after the word address, step per byte.
    always_comb begin
        ack_fall = !write_busy && scl_fall && (cnt == CNT_ACK);
        rd_load  = ack_fall && (((phase == PH_CTRL) && shreg[0]) ||
                                ((phase == PH_RDATA) && m_ack));
        ac_load  = ack_fall && (phase == PH_WADDR);
        ac_inc   = rd_load || (!write_busy && scl_fall &&
                               (cnt == CNT_LAST) && (phase == PH_WDATA));
    end

    // Bit-level protocol engine: phases, shifting, acknowledge, strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            blk       <= '0;
            m_ack     <= 1'b0;
            has_wr    <= 1'b0;
            sda_oe    <= 1'b0;
            wr_valid  <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_commit <= 1'b0;
            wr_abort  <= 1'b0;
        end else begin
            wr_valid  <= 1'b0;
            wr_commit <= 1'b0;
            wr_abort  <= 1'b0;
            if (write_busy) begin
                phase  <= PH_IDLE;
                cnt    <= '0;
                sda_oe <= 1'b0;
                has_wr <= 1'b0;
            end else if (start_ev) begin
                if (phase == PH_WDATA && has_wr)
                    wr_abort <= 1'b1;
                phase  <= PH_CTRL;
                cnt    <= '0;
                sda_oe <= 1'b0;
                has_wr <= 1'b0;
            end else if (stop_ev) begin
                if (phase == PH_WDATA && has_wr) begin
                    if (cnt <= CNT_ONE)
                        wr_commit <= 1'b1;
                    else
                        wr_abort <= 1'b1;
                end
                phase  <= PH_IDLE;
                sda_oe <= 1'b0;
                has_wr <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (scl_rise) begin
                    if (cnt < CNT_LAST) begin
                        if (phase != PH_RDATA)
                            shreg <= {shreg[BYTE_W-2:0], sda_lvl};
                    end else if (cnt == CNT_LAST && phase == PH_RDATA) begin
                        m_ack <= ~sda_lvl;
                    end
                    if (cnt < CNT_ACK)
                        cnt <= cnt + 1'b1;
                end else if (scl_fall) begin
                    if (cnt == CNT_LAST) begin
                        if (phase == PH_RDATA) begin
                            sda_oe <= 1'b0;
                        end else if (phase == PH_CTRL &&
                                     shreg[BYTE_W-1 -: CODE_W] != DEV_CODE) begin
                            phase <= PH_IDLE;
                        end else begin
                            sda_oe <= 1'b1;
                            if (phase == PH_CTRL)
                                blk <= shreg[BLK_W:1];
                            if (phase == PH_WDATA) begin
                                wr_valid <= 1'b1;
                                wr_addr  <= addr;
                                wr_data  <= shreg;
                                has_wr   <= 1'b1;
                            end
                        end
                    end else if (cnt == CNT_ACK) begin
                        cnt    <= '0;
                        sda_oe <= 1'b0;
                        case (phase)
                            PH_CTRL:  phase <= shreg[0] ? PH_RDATA : PH_WADDR;
                            PH_WADDR: phase <= PH_WDATA;
                            PH_RDATA: if (!m_ack) phase <= PH_IDLE;
                            default:  phase <= phase;
                        endcase
                        if (rd_load) begin
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[BYTE_W-1];
                        end
                    end else if (cnt != '0 && phase == PH_RDATA) begin
                        shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~shreg[BYTE_W-2];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/eeprom2w_slave_chk.sv
// Protocol checker for eeprom2w_slave, attached by bind below.
// Assumes scl_s is the slave's sampled clock level.
module eeprom2w_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic sda_oe,
    input logic write_busy,
    input logic wr_valid,
    input logic wr_commit,
    input logic wr_abort
);
    // R11
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> (!$past(scl_s) || $past(write_busy)));

    // R10
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        write_busy |=> !sda_oe);

    // R4
    commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);

    // R3
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_valid, wr_commit, wr_abort}));
endmodule

bind eeprom2w_slave eeprom2w_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_hi), .sda_oe(sda_oe),
    .write_busy(write_busy), .wr_valid(wr_valid),
    .wr_commit(wr_commit), .wr_abort(wr_abort)
);

// File: tb/eeprom2w_slave_test.sv
// Bench for eeprom2w_slave: a bus master model, a vector table of random
// reads, then directed tests for reset, writes, aborts and standby rules.
module eeprom2w_slave_test;
    localparam int Q = 6;
    localparam int NRR = 6;
    localparam logic [10:0] RR_ADDR [NRR] =
        '{11'h000, 11'h0FF, 11'h123, 11'h3C5, 11'h6A9, 11'h7FF};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        write_busy = 1'b0;
    logic        sda_oe, wr_valid, wr_commit, wr_abort;
    logic [10:0] wr_addr, rd_addr;
    logic [7:0]  wr_data, rd_data;
    logic        sda_line;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int wv_n = 0;
    int commits = 0;
    int aborts = 0;
    int viol = 0;
    logic [10:0] wv_addr [8];
    logic [7:0]  wv_data [8];
    logic scl_prev = 1'b1, oe_prev = 1'b0, busy_prev = 1'b0;

    function automatic logic [7:0] fmem(input logic [10:0] a);
        return a[7:0] ^ {5'b01101, a[10:8]};
    endfunction

    assign sda_line = sda_m & ~sda_oe;
    assign rd_data  = fmem(rd_addr);

    eeprom2w_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .write_busy(write_busy), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit),
        .wr_abort(wr_abort), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Output monitor: strobe capture and line-discipline watch (R11).
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid) begin
                if (wv_n < 8) begin
                    wv_addr[wv_n] = wr_addr;
                    wv_data[wv_n] = wr_data;
                end
                wv_n = wv_n + 1;
            end
            if (wr_commit) commits = commits + 1;
            if (wr_abort)  aborts = aborts + 1;
            if (scl_m && scl_prev && (sda_oe != oe_prev) && !write_busy && !busy_prev)
                viol = viol + 1;
        end
        scl_prev  = scl_m;
        oe_prev   = sda_oe;
        busy_prev = write_busy;
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wq(Q);
            scl_m = 1'b1; wq(Q);
            scl_m = 1'b0; wq(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(3);
        acked = ~sda_line;
        wq(Q - 3);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            scl_m = 1'b1; wq(3);
            d[i] = sda_line;
            wq(Q - 3);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = ~mack; wq(Q);
        scl_m = 1'b1; wq(Q);
        scl_m = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    task automatic set_address(input logic [10:0] a);
        bit ak;
        bus_start();
        send_byte({4'b1010, a[10:8], 1'b0}, ak);
        send_byte(a[7:0], ak);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual %0h expected %0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        bit ak;
        logic [7:0] d;
        int base;
        wq(5);
        rst_n = 1'b1;
        wq(4);
        // R1: reset state
        chk(sda_oe == 1'b0, "R1 oe", 32'(sda_oe), 0);
        chk(rd_addr == 11'h000 && wv_n == 0, "R1 addr", 32'(rd_addr), 0);

        // R6: table of random reads
        for (int i = 0; i < NRR; i++) begin
            set_address(RR_ADDR[i]);
            bus_start();
            send_byte(8'hA1, ak);
            recv_byte(1'b0, d);
            bus_stop();
            chk(d == fmem(RR_ADDR[i]), "R6 random read", 32'(d), 32'(fmem(RR_ADDR[i])));
        end

        // R2: wrong device code, then no response without START
        bus_start();
        send_byte(8'h90, ak);
        chk(!ak, "R2 bad code ack", 32'(ak), 0);
        send_byte(8'hA0, ak);
        chk(!ak, "R2 standby after bad code", 32'(ak), 0);
        bus_stop();

        // R3/R4: write three bytes across a block boundary
        base = wv_n;
        bus_start();
        send_byte(8'hAA, ak);
        chk(ak, "R2 good code ack", 32'(ak), 1);
        send_byte(8'hFE, ak);
        send_byte(8'h11, ak);
        send_byte(8'h22, ak);
        send_byte(8'h33, ak);
        chk(ak, "R3 data ack", 32'(ak), 1);
        bus_stop();
        wq(2);
        chk(wv_n - base == 3, "R3 strobe count", 32'(wv_n - base), 3);
        chk(wv_addr[base] == 11'h5FE && wv_data[base] == 8'h11,
            "R3 first byte", {wv_addr[base], wv_data[base]}, {11'h5FE, 8'h11});
        chk(wv_addr[base+2] == 11'h600 && wv_data[base+2] == 8'h33,
            "R3 block crossing", {wv_addr[base+2], wv_data[base+2]}, {11'h600, 8'h33});
        chk(commits == 1 && aborts == 0, "R4 commit", 32'(commits), 1);

        // R9: current-address read, block bits ignored
        bus_start();
        send_byte(8'hA1, ak);
        recv_byte(1'b0, d);
        bus_stop();
        chk(d == fmem(11'h601), "R9 current address", 32'(d), 32'(fmem(11'h601)));

        // R7: sequential read with wrap
        set_address(11'h7FE);
        bus_start();
        send_byte(8'hA1, ak);
        recv_byte(1'b1, d);
        chk(d == fmem(11'h7FE), "R7 seq 0", 32'(d), 32'(fmem(11'h7FE)));
        recv_byte(1'b1, d);
        chk(d == fmem(11'h7FF), "R7 seq 1", 32'(d), 32'(fmem(11'h7FF)));
        recv_byte(1'b0, d);
        chk(d == fmem(11'h000), "R7 wrap", 32'(d), 32'(fmem(11'h000)));

        // R8: after no master acknowledge, clocks are ignored
        begin
            int seen = 0;
            for (int i = 0; i < 9; i++) begin
                scl_m = 1'b1; wq(Q);
                if (sda_oe) seen = seen + 1;
                scl_m = 1'b0; wq(Q);
            end
            chk(seen == 0, "R8 released", 32'(seen), 0);
        end
        send_byte(8'hA0, ak);
        chk(!ak, "R8 standby", 32'(ak), 0);
        bus_stop();

        // R5: STOP in the middle of a data byte
        bus_start();
        send_byte(8'hA0, ak);
        send_byte(8'h40, ak);
        send_byte(8'h5A, ak);
        send_bits(8'hC3, 4);
        bus_stop();
        wq(2);
        chk(aborts == 1 && commits == 1, "R5 mid-byte stop", 32'(aborts), 1);

        // R5: repeated START after data bytes
        bus_start();
        send_byte(8'hA0, ak);
        send_byte(8'h41, ak);
        send_byte(8'h5B, ak);
        bus_start();
        bus_stop();
        wq(2);
        chk(aborts == 2 && commits == 1, "R5 restart", 32'(aborts), 2);

        // R10: START/STOP ignored during busy
        write_busy = 1'b1;
        bus_start();
        send_byte(8'hA0, ak);
        chk(!ak, "R10 busy no ack", 32'(ak), 0);
        write_busy = 1'b0;
        wq(2);
        send_byte(8'hA0, ak);
        chk(!ak, "R10 start ignored", 32'(ak), 0);
        bus_stop();

        // R12: nine clocks with data floating high
        bus_start();
        send_byte(8'hFF, ak);
        chk(!ak, "R12 no ack", 32'(ak), 0);
        send_byte(8'hA0, ak);
        chk(!ak, "R12 standby", 32'(ak), 0);
        bus_stop();

        // R11: line changes only during clock low
        chk(viol == 0, "R11 line discipline", 32'(viol), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule